// File: doc/BRIEF.md
# Hardware Address-Line Gate Sequencer

This block watches the writes a host makes into the slave interface of a peripheral controller and drives an address-line gate pin on its own, so the internal processor never has to handle the host's gate-control commands. Once it has been switched on, it looks for a two-step write pattern: a command write with the value D1h, then a data write. When it sees the data write, it copies one bit of the data byte onto the gate pin. The writes that form the pattern are absorbed. For each of them the block raises a suppress signal so that the input-buffer-full logic does not flag the byte to the processor. A trailing FFh command that comes right after a completed pattern is also absorbed. Every other write passes through to the normal input-buffer path.

A host write counts in a clock cycle when both `host_cs` and `host_wr` are high. The block accepts a write in every cycle and never stalls, so there is no back-pressure at any port. `ibf_suppress` is combinational and belongs to the write presented in that same cycle. The input-buffer-full logic samples it alongside the write. The gate pin is registered and changes in the cycle after the data write that sets it. A pulse on `gate_enable` turns the feature on from the next cycle onward, and only reset turns it off again.

Top module: `a20_gate_seq`

## Requirements
- R1: After reset `gate_out` is 0, the feature is off, and `ibf_suppress` is 0.
- R2: `gate_enable` high in a cycle turns the feature on from the following cycle, and it stays on until reset. While the feature is off, `ibf_suppress` stays 0 for every write and `gate_out` holds its value.
- R3: While the feature is on, a command write (`host_cmd`=1) with data D1h raises `ibf_suppress` in the same cycle. This holds whatever the previous writes were. `ibf_suppress` is never high in a cycle without a write.
- R4: While the feature is on, a data write (`host_cmd`=0) that directly follows a D1h command raises `ibf_suppress`. One cycle later `gate_out` equals bit 1 of that data byte. Bits 0 and 2 to 7 have no effect.
- R5: A command write of FFh that directly follows a data write absorbed under R4 raises `ibf_suppress`. An FFh command at any other time leaves `ibf_suppress` at 0.
- R6: Two D1h commands in a row, followed by a data write, still form a valid pattern and update `gate_out` as in R4.
- R7: If a D1h command is followed by any command other than D1h, that command and the data write after it leave `ibf_suppress` at 0, and `gate_out` does not change.
- R8: `gate_out` changes only through a data write absorbed under R4. A data write outside a valid pattern leaves `gate_out` unchanged and `ibf_suppress` at 0.
- R9: Cycles without a write (`host_cs` or `host_wr` low) do not advance the pattern state or reset it. A D1h command, then idle cycles, then a data write still form a valid pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs | input | 1 | Host chip select; a write counts only while high |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_cmd | input | 1 | 1 = command write, 0 = data write |
| host_din | input | 8 | Byte written by the host |
| gate_enable | input | 1 | Pulse that turns the sequencer on until reset |
| gate_out | output | 1 | Address-line gate level |
| ibf_suppress | output | 1 | High when the write in this cycle is absorbed and must not set input-buffer-full |

## Verification
Several rules are checked by assertions in every cycle: the enable never drops once set, suppression never appears without a write or while the feature is off, a D1h command is always absorbed, the gate pin follows the data bit exactly one cycle after an absorbed data write and holds otherwise, and idle cycles leave the pattern state alone. Other behaviours only show up in the bench's scenarios because they depend on the order of writes. These are a D1h command followed by a foreign command, an FFh command that is absorbed only right after a completed pattern, a repeated D1h, and data writes outside a pattern. The bench runs them as directed cases and in a long random stream that favours the codes D1h and FFh.

// File: rtl/a20_seq_pkg.sv
package a20_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ARMED  = 2'd1,
    SEQ_LOADED = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic fire;
    logic set_cmd;
    logic end_cmd;
    logic data;
  } wr_class_t;

endpackage

// File: rtl/a20_wr_classify.sv
module a20_wr_classify
  import a20_seq_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  SET_CODE = 8'hD1,
  parameter logic [7:0]  END_CODE = 8'hFF
) (
  input  logic              cs,
  input  logic              wr,
  input  logic              is_cmd,
  input  logic [DATA_W-1:0] din,
  output wr_class_t         cls
);
  localparam logic [DATA_W-1:0] SET_W = DATA_W'(SET_CODE);
  localparam logic [DATA_W-1:0] END_W = DATA_W'(END_CODE);

  always_comb begin
    cls.fire    = cs & wr;
    cls.set_cmd = cs & wr & is_cmd & (din == SET_W);
    cls.end_cmd = cs & wr & is_cmd & (din == END_W);
    cls.data    = cs & wr & ~is_cmd;
  end
endmodule

// File: rtl/a20_seq_fsm.sv
module a20_seq_fsm
  import a20_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  wr_class_t  cls,
  output seq_state_t state,
  output logic       absorb,
  output logic       load
);
  seq_state_t nxt;

  always_comb begin
    nxt    = state;
    absorb = 1'b0;
    load   = 1'b0;
    if (active && cls.fire) begin
      if (cls.set_cmd) begin
        absorb = 1'b1;
        nxt    = SEQ_ARMED;
      end else if (cls.end_cmd && state == SEQ_LOADED) begin
        absorb = 1'b1;
        nxt    = SEQ_IDLE;
      end else if (cls.data && state == SEQ_ARMED) begin
        absorb = 1'b1;
        load   = 1'b1;
        nxt    = SEQ_LOADED;
      end else begin
        nxt    = SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SEQ_IDLE;
    else        state <= nxt;
  end

  AST_IDLE_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> state == SEQ_IDLE); // R2
  AST_REPEAT_SET_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cls.set_cmd) |=> state == SEQ_ARMED); // R6
  AST_QUIET_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cls.fire) |=> $stable(state)); // R9
  AST_END_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && state == SEQ_LOADED && cls.end_cmd) |-> absorb); // R5
endmodule

// File: rtl/a20_gate_ctl.sv
module a20_gate_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_strobe,
  input  logic load,
  input  logic load_bit,
  output logic active,
  output logic gate
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      gate   <= 1'b0;
    end else begin
      if (en_strobe) active <= 1'b1;
      if (load)      gate   <= load_bit;
    end
  end

  AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> active); // R2
  AST_GATE_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> gate == $past(load_bit)); // R4
  AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(gate)); // R8
endmodule

// File: rtl/a20_gate_seq.sv
module a20_gate_seq
  import a20_seq_pkg::*;
#(
  parameter int         DATA_W   = 8,
  parameter int         GATE_BIT = 1,
  parameter logic [7:0] SET_CODE = 8'hD1,
  parameter logic [7:0] END_CODE = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs,
  input  logic              host_wr,
  input  logic              host_cmd,
  input  logic [DATA_W-1:0] host_din,
  input  logic              gate_enable,
  output logic              gate_out,
  output logic              ibf_suppress
);
  localparam int SEL_BIT = (GATE_BIT < DATA_W) ? GATE_BIT : 0;

  wr_class_t  cls;
  seq_state_t state;
  logic       active;
  logic       absorb;
  logic       load;

  a20_wr_classify #(
    .DATA_W(DATA_W), .SET_CODE(SET_CODE), .END_CODE(END_CODE)
  ) u_classify (
    .cs(host_cs), .wr(host_wr), .is_cmd(host_cmd), .din(host_din), .cls(cls)
  );

  a20_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .active(active), .cls(cls),
    .state(state), .absorb(absorb), .load(load)
  );

  a20_gate_ctl u_gate (
    .clk(clk), .rst_n(rst_n), .en_strobe(gate_enable), .load(load),
    .load_bit(host_din[SEL_BIT]), .active(active), .gate(gate_out)
  );

  assign ibf_suppress = absorb;

  AST_SUPPRESS_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ibf_suppress |-> (host_cs && host_wr)); // R3
  AST_OFF_PASSES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !ibf_suppress); // R2
  AST_SET_CMD_ABSORBED: assert property (@(posedge clk) disable iff (!rst_n)
    (active && host_cs && host_wr && host_cmd && host_din == DATA_W'(SET_CODE))
      |-> ibf_suppress); // R3
  AST_GATE_ONLY_BY_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (!(host_cs && host_wr && !host_cmd && state == SEQ_ARMED && active))
      |=> $stable(gate_out)); // R8
endmodule

// File: tb/test_a20_gate_seq.sv
module test_a20_gate_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_cs = 1'b0, host_wr = 1'b0, host_cmd = 1'b0;
  logic [7:0] host_din = 8'h00;
  logic       gate_enable = 1'b0;
  logic       gate_out, ibf_suppress;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model: 0 idle, 1 after D1h, 2 after absorbed data
  int   m_st = 0;
  logic m_en = 1'b0;
  logic m_gate = 1'b0;

  always #2.5 clk = ~clk;

  a20_gate_seq i_a20_gate_seq (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_wr(host_wr),
    .host_cmd(host_cmd), .host_din(host_din), .gate_enable(gate_enable),
    .gate_out(gate_out), .ibf_suppress(ibf_suppress)
  );

  function automatic logic exp_absorb(logic cs, logic wr, logic c, logic [7:0] d);
    if (!(m_en && cs && wr)) return 1'b0;
    if (c && d == 8'hD1) return 1'b1;
    if (c && d == 8'hFF && m_st == 2) return 1'b1;
    if (!c && m_st == 1) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string sup_tag(logic cs, logic wr, logic c, logic [7:0] d);
    if (!m_en) return "R2";
    if (!(cs && wr)) return "R9";
    if (c && d == 8'hD1) return "R3";
    if (c && d == 8'hFF) return "R5";
    if (c) return "R7";
    if (m_st == 1) return "R4";
    return "R8";
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; host_cs = 0; host_wr = 0; gate_enable = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_st = 0; m_en = 0; m_gate = 0;
    #1;
    check("R1", gate_out, 1'b0, "gate after reset");
    check("R1", ibf_suppress, 1'b0, "suppress after reset");
  endtask

  // one cycle of stimulus, suppress checked mid-cycle, gate checked after edge
  task automatic op(logic cs, logic wr, logic c, logic [7:0] d, logic en, string tag = "");
    logic es;
    string t;
    @(negedge clk);
    host_cs = cs; host_wr = wr; host_cmd = c; host_din = d; gate_enable = en;
    #1;
    es = exp_absorb(cs, wr, c, d);
    t = (tag != "") ? tag : sup_tag(cs, wr, c, d);
    check(t, ibf_suppress, es, "suppress");
    @(posedge clk);
    if (m_en && cs && wr) begin
      if (c && d == 8'hD1)                  m_st = 1;
      else if (!c && m_st == 1) begin       m_st = 2; m_gate = d[1]; end
      else                                  m_st = 0;
    end
    if (en) m_en = 1'b1;
    #1;
    check((tag != "") ? tag : "R8", gate_out, m_gate, "gate");
    host_cs = 0; host_wr = 0; gate_enable = 0;
  endtask

  task automatic wcmd(logic [7:0] d, string tag = ""); op(1, 1, 1, d, 0, tag); endtask
  task automatic wdat(logic [7:0] d, string tag = ""); op(1, 1, 0, d, 0, tag); endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R2: disabled, pattern passes through, gate holds
    wcmd(8'hD1, "R2"); wdat(8'h02, "R2"); wcmd(8'hFF, "R2");
    op(0, 0, 0, 8'h00, 1, "R2");
    // R3 R4 R5: valid set pattern then trailing FFh
    wcmd(8'hD1, "R3"); wdat(8'h02, "R4"); wcmd(8'hFF, "R5");
    check("R4", gate_out, 1'b1, "gate set by bit 1");
    // R5: lone FFh not absorbed
    wcmd(8'hFF, "R5");
    // R6: D1h twice then data clears
    wcmd(8'hD1, "R6"); wcmd(8'hD1, "R6"); wdat(8'hFD, "R6");
    check("R6", gate_out, 1'b0, "gate cleared, other bits ignored");
    // R7: foreign command breaks pattern
    wcmd(8'hD1, "R7"); wcmd(8'h20, "R7"); wdat(8'h02, "R7");
    check("R7", gate_out, 1'b0, "gate unchanged after broken pattern");
    // R9: idle cycles between command and data
    wcmd(8'hD1, "R9"); op(0, 1, 0, 8'h00, 0, "R9"); op(1, 0, 0, 8'h00, 0, "R9");
    wdat(8'h02, "R9");
    check("R9", gate_out, 1'b1, "gate set across idle cycles");
    // R8: stray data writes
    wdat(8'h00, "R8"); wdat(8'hFD, "R8");
    check("R8", gate_out, 1'b1, "gate held after stray data");
    // R4: other bits ignored when setting
    wcmd(8'hD1, "R4"); wdat(8'hFD, "R4"); wcmd(8'hD1, "R4"); wdat(8'h02, "R4");
    // R2: enable persists, then reset clears everything
    op(0, 0, 0, 8'h00, 0, "R2");
    do_reset();
    wcmd(8'hD1, "R1"); wdat(8'h02, "R1");
    op(0, 0, 0, 8'h00, 1, "R2");
    // random stream biased toward the recognised codes
    for (int i = 0; i < 3000; i++) begin
      int k = int'($urandom_range(0, 9));
      logic [7:0] d = 8'($urandom);
      logic c = 1'($urandom);
      if (k < 3) d = 8'hD1;
      else if (k < 5) d = 8'hFF;
      if (k < 5) c = 1'b1;
      if (k == 9) op(1'($urandom), 1'($urandom), c, d, 1'($urandom_range(0, 19) == 0));
      else        op(1, 1, c, d, 0);
      if (i == 1500) begin do_reset(); op(0, 0, 0, 8'h00, 1, "R2"); end
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule